// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This unit sits beside a five-stage in-order integer pipeline. Four stages can raise an exception: fetch (index 0), decode (1), execute (2) and memory (3). Each of these stages presents a request bit, a 3-bit cause and the program counter of the instruction it holds. In every cycle the unit picks one request to take. The request from the deepest stage wins, because that stage holds the oldest instruction. When the unit takes a request it flushes the faulting stage and every younger stage in that same cycle. On the next clock edge it loads a saved-return-address register with the faulting PC plus 4 and loads the cause register. On that edge it also issues a one-cycle fetch redirect to the fixed handler entry at 0x40000040.

After an exception is taken, further requests are masked until the handler pulses the return input. That pulse sends fetch back to the saved address and lifts the mask. The unit moves no data stream, so every pin is a plain control or status level. There is no valid/ready handshake and no back-pressure: the flush lines and the redirect strobe are commands that the pipeline obeys in the cycle they appear.

Top module: `exc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the saved-PC register, the cause register, the mask bit, the redirect strobe and the redirect target to zero.
- R2: When a request is taken, the saved-PC output holds the winning stage's PC plus 4 from the next clock edge onward.
- R3: When a request is taken, the redirect strobe is high for exactly the following cycle, with target 0x40000040.
- R4: In the cycle a request from stage k is taken, flush lines 0 through k are high and the lines above k are low. With no taken request, every flush line is low.
- R5: The cause register stores the winner's 3-bit code unchanged. The codes are 0 overflow, 1 divide by zero, 2 parity error, 3 system call and 4 bad memory address or page fault.
- R6: When several stages raise requests together, the highest stage index wins, and its PC and cause are the ones recorded.
- R7: A memory-stage (index 3) request raises all four flush lines, so the faulting load is squashed before writeback.
- R8: While the mask is set, requests cause no flush and no redirect, and they leave the saved-PC and cause registers unchanged.
- R9: A return pulse while masked produces a one-cycle redirect to the saved PC on the next edge and clears the mask, so the next request is taken.
- R10: A return pulse while not masked is ignored: no redirect follows.
- R11: A request that arrives in the same cycle as a return pulse, while masked, is ignored: no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld_i | input | NREQ (4) | Exception request per stage, bit 0 = fetch, bit 3 = memory |
| req_cause_i | input | NREQ*3 | Cause code per stage, stage s in bits [3s+2:3s] |
| req_pc_i | input | NREQ*XLEN | PC per stage, stage s in bits [XLEN*s +: XLEN] |
| eret_i | input | 1 | Return-from-exception pulse |
| flush_o | output | NREQ (4) | Squash line per stage, same-cycle |
| epc_o | output | XLEN | Saved return address |
| cause_o | output | 3 | Recorded cause code |
| redir_vld_o | output | 1 | One-cycle fetch-redirect strobe |
| redir_pc_o | output | XLEN | Redirect target |

## Verification
The flush lines are combinational, so they are due in the same cycle as the request. The bench reads them 1 ns after driving inputs on the falling edge. The saved PC, the cause and the handler redirect are due one rising edge after the request, and the return redirect one edge after the pulse. The bench reads each of these at the next falling edge, and it reads them before any input changes that could disturb them.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    EXC_OVF     = 3'd0,
    EXC_DIV0    = 3'd1,
    EXC_PARITY  = 3'd2,
    EXC_SYSCALL = 3'd3,
    EXC_BADADDR = 3'd4
  } exc_cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int XLEN  = 32,
  localparam int STG_W = $clog2(NREQ)
) (
  input  logic [NREQ-1:0]         vld_i,
  input  logic [NREQ*CAUSE_W-1:0] cause_i,
  input  logic [NREQ*XLEN-1:0]    pc_i,
  output logic                    any_o,
  output logic [STG_W-1:0]        idx_o,
  output logic [CAUSE_W-1:0]      cause_o,
  output logic [XLEN-1:0]         pc_o
);
  // Scan from youngest to oldest; a later (deeper) hit overrides.
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    cause_o = '0;
    pc_o    = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (vld_i[i]) begin
        any_o   = 1'b1;
        idx_o   = STG_W'(i);
        cause_o = cause_i[i*CAUSE_W +: CAUSE_W];
        pc_o    = pc_i[i*XLEN +: XLEN];
      end
    end
  end
endmodule

// File: rtl/exc_flush_gen.sv
module exc_flush_gen #(
  parameter int NREQ  = 4,
  localparam int STG_W = $clog2(NREQ)
) (
  input  logic             take_i,
  input  logic [STG_W-1:0] idx_i,
  output logic [NREQ-1:0]  flush_o
);
  // Faulting stage and everything younger (lower index) are squashed.
  for (genvar g = 0; g < NREQ; g++) begin : g_stage
    assign flush_o[g] = take_i && (idx_i >= STG_W'(g));
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int          NREQ        = 4,
  parameter int          XLEN        = 32,
  parameter logic [31:0] HANDLER_VEC = 32'h4000_0040,
  localparam int         STG_W       = $clog2(NREQ)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREQ-1:0]         req_vld_i,
  input  logic [NREQ*CAUSE_W-1:0] req_cause_i,
  input  logic [NREQ*XLEN-1:0]    req_pc_i,
  input  logic                    eret_i,
  output logic [NREQ-1:0]         flush_o,
  output logic [XLEN-1:0]         epc_o,
  output logic [CAUSE_W-1:0]      cause_o,
  output logic                    redir_vld_o,
  output logic [XLEN-1:0]         redir_pc_o
);
  logic               any_req;
  logic [STG_W-1:0]   win_idx;
  logic [CAUSE_W-1:0] win_cause;
  logic [XLEN-1:0]    win_pc;
  logic               mask_q;
  logic               take;

  exc_arbiter #(.NREQ(NREQ), .XLEN(XLEN)) u_arb (
    .vld_i   (req_vld_i),
    .cause_i (req_cause_i),
    .pc_i    (req_pc_i),
    .any_o   (any_req),
    .idx_o   (win_idx),
    .cause_o (win_cause),
    .pc_o    (win_pc)
  );

  assign take = any_req && !mask_q;

  exc_flush_gen #(.NREQ(NREQ)) u_flush (
    .take_i  (take),
    .idx_i   (win_idx),
    .flush_o (flush_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_o       <= '0;
      cause_o     <= '0;
      mask_q      <= 1'b0;
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
    end else begin
      redir_vld_o <= 1'b0;
      if (take) begin
        epc_o       <= win_pc + XLEN'(4);
        cause_o     <= win_cause;
        mask_q      <= 1'b1;
        redir_vld_o <= 1'b1;
        redir_pc_o  <= XLEN'(HANDLER_VEC);
      end else if (eret_i && mask_q) begin
        mask_q      <= 1'b0;
        redir_vld_o <= 1'b1;
        redir_pc_o  <= epc_o;
      end
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int          NREQ        = 4,
  parameter int          XLEN        = 32,
  parameter logic [31:0] HANDLER_VEC = 32'h4000_0040
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req_vld_i,
  input logic [NREQ-1:0] flush_o,
  input logic [XLEN-1:0] epc_o,
  input logic [2:0]      cause_o,
  input logic            redir_vld_o,
  input logic [XLEN-1:0] redir_pc_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (epc_o == '0 && cause_o == '0 && !redir_vld_o && redir_pc_o == '0));

  assert_handler_redirect_R3: assert property (@(posedge clk) disable iff (rst)
    (flush_o != '0) |=> (redir_vld_o && redir_pc_o == XLEN'(HANDLER_VEC)));

  assert_flush_thermo_R4: assert property (@(posedge clk) disable iff (rst)
    (flush_o & (flush_o + NREQ'(1))) == '0);

  assert_oldest_covered_R6: assert property (@(posedge clk) disable iff (rst)
    (flush_o != '0) |-> ((req_vld_i & ~flush_o) == '0));

  assert_masked_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    (flush_o != '0) |=> (flush_o == '0));

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flush_o == '0) |=> ($stable(epc_o) && $stable(cause_o)));
endmodule

bind exc_ctrl exc_ctrl_chk #(.NREQ(NREQ), .XLEN(XLEN), .HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_vld_i   (req_vld_i),
  .flush_o     (flush_o),
  .epc_o       (epc_o),
  .cause_o     (cause_o),
  .redir_vld_o (redir_vld_o),
  .redir_pc_o  (redir_pc_o)
);

// File: tb/exc_ctrl_tb_top.sv
module exc_ctrl_tb_top;
  localparam int NREQ = 4;
  localparam int XLEN = 32;
  localparam logic [31:0] HVEC = 32'h4000_0040;
  localparam int NVEC = 8;

  // {req_vld[3:0], causes[11:0], exp_flush[3:0], exp_cause[2:0], exp_stage[1:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'b0001, 12'o0003, 4'b0001, 3'd3, 2'd0},
    {4'b0010, 12'o0000, 4'b0011, 3'd0, 2'd1},
    {4'b0100, 12'o0100, 4'b0111, 3'd1, 2'd2},
    {4'b1000, 12'o4000, 4'b1111, 3'd4, 2'd3},
    {4'b0101, 12'o0002, 4'b0111, 3'd0, 2'd2},
    {4'b1111, 12'o4123, 4'b1111, 3'd4, 2'd3},
    {4'b0011, 12'o0023, 4'b0011, 3'd2, 2'd1},
    {4'b1010, 12'o1000, 4'b1111, 3'd1, 2'd3}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NREQ-1:0]      req_vld = '0;
  logic [NREQ*3-1:0]    req_cause = '0;
  logic [NREQ*XLEN-1:0] req_pc = '0;
  logic                 eret = 1'b0;
  logic [NREQ-1:0]      flush;
  logic [XLEN-1:0]      epc;
  logic [2:0]           cause;
  logic                 redir_vld;
  logic [XLEN-1:0]      redir_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_ctrl #(.NREQ(NREQ), .XLEN(XLEN), .HANDLER_VEC(HVEC)) dut_i (
    .clk(clk), .rst(rst), .req_vld_i(req_vld), .req_cause_i(req_cause),
    .req_pc_i(req_pc), .eret_i(eret), .flush_o(flush), .epc_o(epc),
    .cause_o(cause), .redir_vld_o(redir_vld), .redir_pc_o(redir_pc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pc_of(int v, int s);
    return 32'h1000_0000 + 32'(v) * 32'h100 + 32'(s) * 32'h10;
  endfunction

  task automatic set_pcs(int v);
    for (int s = 0; s < NREQ; s++) req_pc[s*XLEN +: XLEN] = pc_of(v, s);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(epc == '0 && cause == '0, "R1 regs", {epc[28:0], cause}, 32'd0);
    check(!redir_vld && redir_pc == '0, "R1 redirect", redir_pc, 32'd0);
    check(flush == '0, "R1 flush", 32'(flush), 32'd0);
    rst = 1'b0;

    // R10: return pulse while unmasked is ignored
    @(negedge clk); eret = 1'b1;
    @(negedge clk); eret = 1'b0;
    check(!redir_vld, "R10 no redirect", 32'(redir_vld), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  vl;
      logic [11:0] cs;
      logic [3:0]  ef;
      logic [2:0]  ec;
      logic [1:0]  es;
      logic [31:0] exp_epc;
      {vl, cs, ef, ec, es} = VEC[v];
      exp_epc = pc_of(v, int'(es)) + 32'd4;
      @(negedge clk);
      req_vld = vl; req_cause = cs; set_pcs(v);
      #1;
      check(flush == ef, "R4/R6/R7 flush", 32'(flush), 32'(ef));
      @(negedge clk);
      check(epc == exp_epc, "R2/R6 epc", epc, exp_epc);
      check(cause == ec, "R5/R6 cause", 32'(cause), 32'(ec));
      check(redir_vld && redir_pc == HVEC, "R3 handler redirect", redir_pc, HVEC);
      req_vld = '0; eret = 1'b1;
      @(negedge clk);
      eret = 1'b0;
      check(redir_vld && redir_pc == exp_epc, "R9 return redirect", redir_pc, exp_epc);
      @(negedge clk);
      check(!redir_vld, "R3 strobe one cycle", 32'(redir_vld), 32'd0);
    end

    // R8: requests while masked are ignored
    @(negedge clk);
    req_vld = 4'b0010; req_cause = 12'o0010; set_pcs(9);
    @(negedge clk);
    check(epc == pc_of(9, 1) + 32'd4, "R2 setup", epc, pc_of(9, 1) + 32'd4);
    req_vld = 4'b1000; req_cause = 12'o2000; set_pcs(10);
    #1;
    check(flush == '0, "R8 no flush", 32'(flush), 32'd0);
    @(negedge clk);
    check(!redir_vld, "R8 no redirect", 32'(redir_vld), 32'd0);
    check(epc == pc_of(9, 1) + 32'd4, "R8 epc held", epc, pc_of(9, 1) + 32'd4);
    check(cause == 3'd1, "R8 cause held", 32'(cause), 32'd1);

    // R11: request arriving with the return pulse is ignored
    eret = 1'b1; req_vld = 4'b0100; req_cause = 12'o0400; set_pcs(11);
    #1;
    check(flush == '0, "R11 no flush", 32'(flush), 32'd0);
    @(negedge clk);
    eret = 1'b0; req_vld = '0;
    check(redir_vld && redir_pc == pc_of(9, 1) + 32'd4, "R11/R9 return",
          redir_pc, pc_of(9, 1) + 32'd4);
    check(cause == 3'd1, "R11 cause held", 32'(cause), 32'd1);

    // R9: unmasked again, the next request is taken
    req_vld = 4'b0001; req_cause = 12'o0004; set_pcs(12);
    #1;
    check(flush == 4'b0001, "R9 retaken flush", 32'(flush), 32'h1);
    @(negedge clk);
    req_vld = '0;
    check(cause == 3'd4 && epc == pc_of(12, 0) + 32'd4, "R9 retaken regs",
          epc, pc_of(12, 0) + 32'd4);

    // R1: reset mid-handler clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(epc == '0 && cause == '0 && !redir_vld, "R1 reset again", epc, 32'd0);
    req_vld = 4'b0100; req_cause = 12'o0300; set_pcs(13);
    #1;
    check(flush == 4'b0111, "R1 mask cleared", 32'(flush), 32'h7);
    @(negedge clk);
    req_vld = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule